// File: doc/BRIEF.md
# Bus-Size Matcher With Byte Swapping

This block connects a narrow or full-width external data port to a 36-bit long-word path that leads to a FIFO. The port can run 36, 18 or 9 bits wide. A write gathers one or more narrow transfers into one long word and pushes it toward the FIFO. A read takes the long word at the head of the FIFO and hands it out as one or more narrow transfers. Before a long word is pushed, or after it is taken, the block reorders its four 9-bit lanes in one of four patterns. One size code sends the access to a mailbox path instead of the FIFO.

The width and reorder selects pass through two registers. The first captures the pins on every clock edge. The second takes that value only when no long word is partly transferred. A long word therefore always finishes with the width and pattern it started with. Every result is combinational with the accepted transfer, so no data is buffered at the edge of the block.

On the external port, a transfer happens in any cycle where `ext_valid` and `ext_ready` are both high. The source must hold `ext_write` and the data steady until that cycle. Toward the FIFO, `push_valid`/`push_ready` and `pop_valid`/`pop_ready` follow the same rule. `pop_data` must stay stable while `pop_valid` is high and the pop has not been accepted, because the block reads it in place.

Top module: `busmatch_swapper`

## Requirements
- R1: After reset the active width is 36 bits, the reorder pattern is identity and the transfer counter is at zero. A single write transfer then pushes its data unchanged.
- R2: Width code 00 moves a long word in one transfer, using all 36 port bits.
- R3: Width code 01 moves a long word in two transfers on port bits [17:0]. The first transfer carries long-word bits [35:18]. Port input bits above 17 are ignored, and port output bits above 17 read zero.
- R4: Width code 10 moves a long word in four transfers on port bits [8:0]. Transfer k (counting from 0) carries long-word bits [35-9k : 27-9k]. Port input bits above 8 are ignored, and port output bits above 8 read zero.
- R5: A write transfer that is not the last of its long word is accepted at once (`ext_ready` high) and does not assert `push_valid`. `push_valid` rises only during the last write transfer.
- R6: For a FIFO read, `ext_ready` equals `pop_valid`, and `ext_rdata` holds the selected piece in the same cycle. `pop_ready` is asserted only on the accepted last transfer.
- R7: The lanes are numbered 3 (bits 35:27) down to 0. Reorder code 00 leaves them in place, 01 reverses all four, 10 exchanges lanes 3,2 with lanes 1,0, and 11 exchanges the two lanes inside each 18-bit half. The reorder applies to the pushed word and to the popped word.
- R8: A change on `size_sel` or `swap_sel` is captured at one rising edge and governs transfers from the following rising edge onward, provided no long word is partly transferred.
- R9: A change of width or reorder select made partway through a long word does not affect that long word. The new value applies to the next one.
- R10: Width code 11 routes each transfer to the mailbox. A write pulses `mbx_wr_valid` with all 36 bits of `ext_wdata`. A read pulses `mbx_rd_valid` and returns `mbx_rd_data` unchanged. Neither the FIFO push nor the FIFO pop is touched, and `ext_ready` stays high.
- R11: While the last write transfer waits with `push_ready` low, `ext_ready` is low and `push_valid` stays high.
- R12: `ext_oe` is high exactly when `ext_write` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_valid | input | 1 | External transfer request |
| ext_ready | output | 1 | External transfer can complete this cycle |
| ext_write | input | 1 | 1 = write toward the block, 0 = read |
| ext_wdata | input | 36 | External write data, right-aligned for narrow widths |
| ext_rdata | output | 36 | External read data, right-aligned, unused bits zero |
| ext_oe | output | 1 | Enable for the external output drivers |
| size_sel | input | 2 | Width code: 00 = 36, 01 = 18, 10 = 9, 11 = mailbox |
| swap_sel | input | 2 | Lane reorder code |
| push_valid | output | 1 | Gathered long word offered to the FIFO |
| push_ready | input | 1 | FIFO accepts the long word |
| push_data | output | 36 | Reordered long word to the FIFO |
| pop_valid | input | 1 | FIFO head word available |
| pop_ready | output | 1 | FIFO head word consumed |
| pop_data | input | 36 | FIFO head word |
| mbx_wr_valid | output | 1 | Mailbox write strobe |
| mbx_wr_data | output | 36 | Mailbox write data |
| mbx_rd_valid | output | 1 | Mailbox read strobe |
| mbx_rd_data | input | 36 | Mailbox read data |

## Verification
Push, pop, mailbox strobes, read data and `ext_ready` all respond in the same cycle as the transfer that causes them. The bench therefore drives each transfer at the falling edge and samples one nanosecond later, before the rising edge commits it. A select change takes effect two rising edges later. The bench waits two edges after each reconfiguration. One directed case places a transfer between the two edges, where the old width must still apply, and a second case changes the selects in the middle of a long word. Random long words mix widths, patterns, directions, FIFO stalls and empty-FIFO waits. Each one is compared against a bench model of slicing and lane reordering.

// File: rtl/bm_pkg.sv
package bm_pkg;
  parameter int unsigned LANE_W = 9;
  localparam int unsigned LANES  = 4;
  localparam int unsigned HALF_W = LANE_W * 2;
  localparam int unsigned WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_HALF = 2'b01,
    SZ_LANE = 2'b10,
    SZ_MBOX = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    SW_NONE    = 2'b00,
    SW_REVERSE = 2'b01,
    SW_HALVES  = 2'b10,
    SW_INHALF  = 2'b11
  } swap_e;

  // index of the last transfer in a long word for a width code
  function automatic logic [1:0] last_index(size_e s);
    case (s)
      SZ_HALF: last_index = 2'd1;
      SZ_LANE: last_index = 2'd3;
      default: last_index = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/bm_cfg_ctrl.sv
module bm_cfg_ctrl
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] size_in,
  input  logic [1:0] swap_in,
  input  logic       beat_fire,
  output size_e      size_eff,
  output swap_e      swap_eff,
  output logic [1:0] beat_idx,
  output logic       beat_last
);
  size_e      size_q;
  swap_e      swap_q;
  logic [1:0] cnt;
  logic       hold;

  assign beat_idx  = cnt;
  assign beat_last = (cnt == last_index(size_eff));
  // selects are frozen while a long word is partly moved
  assign hold      = (cnt != 2'd0) || (beat_fire && !beat_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= SZ_LONG;
      swap_q   <= SW_NONE;
      size_eff <= SZ_LONG;
      swap_eff <= SW_NONE;
      cnt      <= 2'd0;
    end else begin
      size_q <= size_e'(size_in);
      swap_q <= swap_e'(swap_in);
      if (!hold) begin
        size_eff <= size_q;
        swap_eff <= swap_q;
      end
      if (beat_fire) cnt <= beat_last ? 2'd0 : cnt + 2'd1;
    end
  end

  a_r9_frozen_midword: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd0) |=> ($stable(size_eff) && $stable(swap_eff)));

  a_r8_adopt_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd0 && !beat_fire) |=> (size_eff == $past(size_q) && swap_eff == $past(swap_q)));

  a_r5_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !beat_last) |=> (cnt == 2'($past(cnt) + 2'd1)));
endmodule

// File: rtl/bm_swap.sv
module bm_swap
  import bm_pkg::*;
#(
  parameter int unsigned LW = LANE_W
) (
  input  swap_e                mode,
  input  logic [LW*LANES-1:0]  din,
  output logic [LW*LANES-1:0]  dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned S_REV  = LANES - 1 - l;
    localparam int unsigned S_HALF = l ^ 2;
    localparam int unsigned S_IN   = l ^ 1;
    always_comb begin
      case (mode)
        SW_REVERSE: dout[l*LW +: LW] = din[S_REV*LW +: LW];
        SW_HALVES:  dout[l*LW +: LW] = din[S_HALF*LW +: LW];
        SW_INHALF:  dout[l*LW +: LW] = din[S_IN*LW +: LW];
        default:    dout[l*LW +: LW] = din[l*LW +: LW];
      endcase
    end
  end
endmodule

// File: rtl/bm_wr_gather.sv
module bm_wr_gather
  import bm_pkg::*;
#(
  parameter int unsigned LW = LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  size_e               size_eff,
  input  logic                take,
  input  logic [LW*LANES-1:0] din,
  output logic [LW*LANES-1:0] gathered
);
  localparam int unsigned WW = LW * LANES;
  localparam int unsigned HW = LW * 2;

  logic [WW-1:0] acc;
  logic [WW-1:0] shift_half;
  logic [WW-1:0] shift_lane;

  // earlier transfers sit above the current one: first transfer ends up most significant
  assign shift_half = {acc[WW-HW-1:0], din[HW-1:0]};
  assign shift_lane = {acc[WW-LW-1:0], din[LW-1:0]};

  always_comb begin
    case (size_eff)
      SZ_HALF: gathered = shift_half;
      SZ_LANE: gathered = shift_lane;
      default: gathered = din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (take) acc <= (size_eff == SZ_HALF) ? shift_half : shift_lane;
  end
endmodule

// File: rtl/bm_rd_slice.sv
module bm_rd_slice
  import bm_pkg::*;
#(
  parameter int unsigned LW = LANE_W
) (
  input  size_e               size_eff,
  input  logic [1:0]          idx,
  input  logic [LW*LANES-1:0] word,
  output logic [LW*LANES-1:0] piece
);
  localparam int unsigned WW = LW * LANES;
  localparam int unsigned HW = LW * 2;

  int unsigned lane_sel;
  assign lane_sel = LANES - 1 - int'(idx);

  always_comb begin
    piece = '0;
    case (size_eff)
      SZ_HALF: piece[HW-1:0] = idx[0] ? word[HW-1:0] : word[WW-1 -: HW];
      SZ_LANE: piece[LW-1:0] = word[lane_sel*LW +: LW];
      default: piece = word;
    endcase
  end
endmodule

// File: rtl/busmatch_swapper.sv
module busmatch_swapper
  import bm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_valid,
  output logic        ext_ready,
  input  logic        ext_write,
  input  logic [35:0] ext_wdata,
  output logic [35:0] ext_rdata,
  output logic        ext_oe,
  input  logic [1:0]  size_sel,
  input  logic [1:0]  swap_sel,
  output logic        push_valid,
  input  logic        push_ready,
  output logic [35:0] push_data,
  input  logic        pop_valid,
  output logic        pop_ready,
  input  logic [35:0] pop_data,
  output logic        mbx_wr_valid,
  output logic [35:0] mbx_wr_data,
  output logic        mbx_rd_valid,
  input  logic [35:0] mbx_rd_data
);
  size_e         size_eff;
  swap_e         swap_eff;
  logic [1:0]    beat_idx;
  logic          beat_last;
  logic          mbox;
  logic          fire;
  logic [WORD_W-1:0] gathered;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rd_piece;

  assign mbox = (size_eff == SZ_MBOX);

  always_comb begin
    if (mbox)           ext_ready = 1'b1;
    else if (ext_write) ext_ready = beat_last ? push_ready : 1'b1;
    else                ext_ready = pop_valid;
  end

  assign fire = ext_valid && ext_ready;

  bm_cfg_ctrl u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_in   (size_sel),
    .swap_in   (swap_sel),
    .beat_fire (fire),
    .size_eff  (size_eff),
    .swap_eff  (swap_eff),
    .beat_idx  (beat_idx),
    .beat_last (beat_last)
  );

  bm_wr_gather #(.LW(LANE_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .size_eff (size_eff),
    .take     (fire && ext_write && !mbox && !beat_last),
    .din      (ext_wdata),
    .gathered (gathered)
  );

  bm_swap #(.LW(LANE_W)) u_wr_swap (
    .mode (swap_eff),
    .din  (gathered),
    .dout (push_data)
  );

  bm_swap #(.LW(LANE_W)) u_rd_swap (
    .mode (swap_eff),
    .din  (pop_data),
    .dout (rd_word)
  );

  bm_rd_slice #(.LW(LANE_W)) u_slice (
    .size_eff (size_eff),
    .idx      (beat_idx),
    .word     (rd_word),
    .piece    (rd_piece)
  );

  assign push_valid   = ext_valid && ext_write && !mbox && beat_last;
  assign pop_ready    = fire && !ext_write && !mbox && beat_last;
  assign mbx_wr_valid = ext_valid && ext_write && mbox;
  assign mbx_wr_data  = ext_wdata;
  assign mbx_rd_valid = ext_valid && !ext_write && mbox;
  assign ext_oe       = !ext_write;
  assign ext_rdata    = ext_write ? '0 : (mbox ? mbx_rd_data : rd_piece);

  a_r11_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |-> !ext_ready);

  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_valid, pop_ready, mbx_wr_valid, mbx_rd_valid}));

  a_r12_drivers_off_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ext_write |-> !ext_oe);

  a_r6_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ready |-> pop_valid);
endmodule

// File: tb/test_busmatch_swapper.sv
`timescale 1ns/1ps
module test_busmatch_swapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_valid, ext_ready, ext_write, ext_oe;
  logic [35:0] ext_wdata, ext_rdata;
  logic [1:0]  size_sel, swap_sel;
  logic        push_valid, push_ready, pop_valid, pop_ready;
  logic [35:0] push_data, pop_data;
  logic        mbx_wr_valid, mbx_rd_valid;
  logic [35:0] mbx_wr_data, mbx_rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int m_size = 0;
  int m_sw = 0;

  always #2 clk = ~clk;

  busmatch_swapper i_busmatch_swapper (
    .clk(clk), .rst_n(rst_n),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_write(ext_write),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_oe(ext_oe),
    .size_sel(size_sel), .swap_sel(swap_sel),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .mbx_wr_valid(mbx_wr_valid), .mbx_wr_data(mbx_wr_data),
    .mbx_rd_valid(mbx_rd_valid), .mbx_rd_data(mbx_rd_data)
  );

  function automatic logic [35:0] exp_swap(input logic [35:0] w, input int m);
    case (m)
      1: exp_swap = {w[8:0], w[17:9], w[26:18], w[35:27]};
      2: exp_swap = {w[17:0], w[35:18]};
      3: exp_swap = {w[26:18], w[35:27], w[8:0], w[17:9]};
      default: exp_swap = w;
    endcase
  endfunction

  function automatic logic [35:0] exp_piece(input logic [35:0] w, input int sz, input int k);
    exp_piece = '0;
    if (sz == 1) exp_piece[17:0] = (k == 0) ? w[35:18] : w[17:0];
    else if (sz == 2) exp_piece[8:0] = w[35-9*k -: 9];
    else exp_piece = w;
  endfunction

  function automatic int nbeats(input int sz);
    nbeats = (sz == 1) ? 2 : (sz == 2) ? 4 : 1;
  endfunction

  function automatic string size_tag(input int sz);
    size_tag = (sz == 1) ? "R3" : (sz == 2) ? "R4" : "R2";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_cfg(input int sz, input int sw);
    @(negedge clk);
    ext_valid = 1'b0;
    size_sel = 2'(sz);
    swap_sel = 2'(sw);
    m_size = sz;
    m_sw = sw;
    repeat (2) @(posedge clk);
  endtask

  // drive one write transfer k of long word w (upper junk bits set)
  task automatic drive_wr_beat(input logic [35:0] w, input int k);
    logic [35:0] wd, junk;
    junk = {$urandom(), $urandom()};
    wd = exp_piece(w, m_size, k);
    if (m_size == 1) wd[35:18] = junk[17:0];
    if (m_size == 2) wd[35:9] = junk[26:0];
    ext_valid = 1'b1;
    ext_write = 1'b1;
    ext_wdata = wd;
  endtask

  task automatic write_long(input logic [35:0] w, input int stall);
    int n;
    n = nbeats(m_size);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      drive_wr_beat(w, k);
      if (k == n - 1) begin
        for (int s = 0; s < stall; s++) begin
          push_ready = 1'b0;
          #1;
          chk(push_valid && !ext_ready, "R11 stall", {34'b0, push_valid, ext_ready}, 36'h2);
          @(negedge clk);
        end
        push_ready = 1'b1;
        #1;
        chk(push_valid && ext_ready, "R5 final push", {34'b0, push_valid, ext_ready}, 36'h3);
        chk(push_data == exp_swap(w, m_sw), {size_tag(m_size), " R7 push data"}, push_data, exp_swap(w, m_sw));
        chk(ext_oe == 1'b0, "R12 write oe", {35'b0, ext_oe}, 36'h0);
      end else begin
        #1;
        chk(!push_valid && ext_ready, "R5 early beat", {34'b0, push_valid, ext_ready}, 36'h1);
      end
    end
    @(negedge clk);
    ext_valid = 1'b0;
  endtask

  task automatic read_long(input logic [35:0] d, input int delay);
    int n;
    logic [35:0] e;
    n = nbeats(m_size);
    for (int s = 0; s < delay; s++) begin
      @(negedge clk);
      ext_valid = 1'b1; ext_write = 1'b0; pop_valid = 1'b0;
      #1;
      chk(!ext_ready && !pop_ready, "R6 empty wait", {34'b0, ext_ready, pop_ready}, 36'h0);
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ext_valid = 1'b1; ext_write = 1'b0; pop_valid = 1'b1; pop_data = d;
      #1;
      e = exp_piece(exp_swap(d, m_sw), m_size, k);
      chk(ext_rdata == e, {size_tag(m_size), " R7 read data"}, ext_rdata, e);
      chk(ext_ready && (pop_ready == (k == n - 1)), "R6 pop timing",
          {34'b0, ext_ready, pop_ready}, {34'b0, 1'b1, (k == n - 1)});
      chk(ext_oe == 1'b1, "R12 read oe", {35'b0, ext_oe}, 36'h1);
    end
    @(negedge clk);
    ext_valid = 1'b0; pop_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] w;
    void'($urandom(32'd7215));
    rst_n = 1'b0; ext_valid = 1'b0; ext_write = 1'b1; ext_wdata = '0;
    size_sel = 2'b01; swap_sel = 2'b11; push_ready = 1'b1;
    pop_valid = 1'b0; pop_data = '0; mbx_rd_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!push_valid && !pop_ready && !mbx_wr_valid && !mbx_rd_valid, "R1 reset outputs",
        {32'b0, push_valid, pop_ready, mbx_wr_valid, mbx_rd_valid}, 36'h0);
    // R1: reset config is long/identity; first beat pushes before new selects land
    @(negedge clk);
    rst_n = 1'b1;
    m_size = 0; m_sw = 0;
    ext_valid = 1'b1; ext_write = 1'b1; ext_wdata = 36'h9_1234_5678;
    #1;
    chk(push_valid && push_data == 36'h9_1234_5678, "R1 first push", push_data, 36'h9_1234_5678);
    @(negedge clk);
    ext_valid = 1'b0;

    // directed: every width x every pattern, both directions
    for (int sz = 0; sz < 3; sz++)
      for (int sw = 0; sw < 4; sw++) begin
        do_cfg(sz, sw);
        write_long(36'h1_2345_6789 ^ 36'(sz * 3 + sw), 0);
        read_long(36'hF_EDCB_A987 ^ 36'(sz + sw * 5), 0);
      end

    // R11 and R6 boundary waits
    do_cfg(2, 1);
    write_long(36'hA_5A5A_5A5A, 2);
    read_long(36'h5_A5A5_A5A5, 2);

    // R8: selects take effect two edges after being driven
    do_cfg(0, 0);
    @(negedge clk);
    size_sel = 2'b10;
    @(negedge clk);
    ext_valid = 1'b1; ext_write = 1'b1; ext_wdata = 36'h3_3333_3333;
    #1;
    chk(push_valid && push_data == 36'h3_3333_3333, "R8 old width still active", push_data, 36'h3_3333_3333);
    m_size = 2;
    @(negedge clk);
    drive_wr_beat(36'h4_4444_4444, 0);
    #1;
    chk(!push_valid, "R8 new width active", {35'b0, push_valid}, 36'h0);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      drive_wr_beat(36'h4_4444_4444, k);
    end
    #1;
    chk(push_valid && push_data == 36'h4_4444_4444, "R8 byte word", push_data, 36'h4_4444_4444);
    @(negedge clk);
    ext_valid = 1'b0;

    // R9: change selects mid long word
    do_cfg(2, 0);
    w = 36'h1_0203_0405;
    @(negedge clk);
    drive_wr_beat(w, 0);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      size_sel = 2'b00; swap_sel = 2'b01;
      drive_wr_beat(w, k);
    end
    #1;
    chk(push_valid && push_data == w, "R9 midword change deferred", push_data, w);
    @(negedge clk);
    ext_valid = 1'b0;
    m_size = 0; m_sw = 1;
    write_long(36'h8_0706_0504, 0);

    // R10 mailbox
    do_cfg(3, 2);
    @(negedge clk);
    ext_valid = 1'b1; ext_write = 1'b1; ext_wdata = 36'hC_0FFE_E123; push_ready = 1'b0;
    #1;
    chk(mbx_wr_valid && !push_valid && ext_ready && mbx_wr_data == 36'hC_0FFE_E123,
        "R10 mailbox write", mbx_wr_data, 36'hC_0FFE_E123);
    @(negedge clk);
    ext_write = 1'b0; pop_valid = 1'b1; pop_data = 36'h1_1111_1111; mbx_rd_data = 36'h7_ABCD_EF01;
    push_ready = 1'b1;
    #1;
    chk(mbx_rd_valid && !pop_ready && ext_ready && ext_rdata == 36'h7_ABCD_EF01,
        "R10 mailbox read", ext_rdata, 36'h7_ABCD_EF01);
    @(negedge clk);
    ext_valid = 1'b0; pop_valid = 1'b0;

    // constrained random
    for (int it = 0; it < 150; it++) begin
      do_cfg(int'($urandom_range(2, 0)), int'($urandom_range(3, 0)));
      w = {$urandom(), $urandom()};
      if ($urandom_range(1, 0) == 1) write_long(w, int'($urandom_range(2, 0)));
      else read_long(w, int'($urandom_range(2, 0)));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule